// File: doc/BRIEF.md
# Low-Power UART Receiver with Sleep Wakeup

This block is the receive half of a serial port that keeps working on its own kernel clock while the rest of the chip is halted. It watches an asynchronous RX line, reassembles 8-bit characters (one start bit, eight data bits sent least significant first, no parity, one stop bit) and holds the last good character for software. While the system reports that it is in stop mode, the block raises a wakeup request when one chosen event occurs. The event can be a confirmed start bit, a received address character equal to this node's address, or a newly filled receive buffer.

The bit timing comes from a fractional divisor. It gives the number of kernel clocks per bit as an unsigned fixed-point value with 8 fraction bits. Each bit is sampled once, near its centre, and the sampling phase carries its fractional error forward, so the error does not build up over the frame. A 32.768 kHz clock can therefore receive 9600 baud (divisor 873, about 3.41 clocks per bit). A faster kernel clock simply takes a larger divisor.

Top module: `lprx_top`

## Requirements
- R1: After a synchronous reset, `rx_data_o` is 0 and `rx_ne_o`, `addr_match_o`, `frame_err_o` and `wake_o` are all low.
- R2: `baud_div_i` gives the number of clocks per bit with 8 fraction bits and must be at least 768 (3 clocks per bit). Characters are received correctly at divisors 873, 768 and 4096. The sampling clocks never fire in two consecutive cycles.
- R3: A falling edge on the line followed by a low start sample begins a frame. Data bits are taken least significant bit first. If the stop sample is high, the byte appears on `rx_data_o` and `rx_ne_o` is set. The byte is held until the next good frame.
- R4: If the stop sample is low, `frame_err_o` is set and neither `rx_ne_o` nor `rx_data_o` changes. A one-cycle `rd_i` clears both `rx_ne_o` and `frame_err_o`; a new frame result in the same cycle wins over the clear.
- R5: A low pulse that has ended by the centre of the start bit is discarded. It produces no flag, no data and no wakeup.
- R6: `wake_sel_i` selects the wake source: 2'b00 confirmed start bit, 2'b01 address match, 2'b10 receive buffer filled, 2'b11 no source.
- R7: With source 2'b00 and `stop_i` high, a start bit that is confirmed low at its centre raises `wake_o`, even if that frame later fails its stop bit.
- R8: `addr_match_o` is refreshed on every good frame. It is high only when bit 7 of the character is 1 and bits 6:0 equal `node_addr_i`. With source 2'b01 and `stop_i` high, such a frame raises `wake_o`; any other frame does not.
- R9: With source 2'b10 and `stop_i` high, every good frame raises `wake_o`. A frame that fails its stop bit does not.
- R10: `wake_o` stays high until a one-cycle `wake_clr_i`. A wake event in the same cycle wins over the clear.
- R11: While `stop_i` is low, no event raises `wake_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock (32.768 kHz class or faster) |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| stop_i | input | 1 | High while the system is in stop mode |
| wake_sel_i | input | 2 | Wake source select (R6 encoding) |
| node_addr_i | input | 7 | Address of this node |
| baud_div_i | input | 16 | Clocks per bit, 8 fraction bits |
| rd_i | input | 1 | One-cycle read strobe for the received byte |
| wake_clr_i | input | 1 | One-cycle clear of the wakeup request |
| rx_data_o | output | 8 | Last good received character |
| rx_ne_o | output | 1 | Receive buffer not empty |
| addr_match_o | output | 1 | Last good character was this node's address |
| frame_err_o | output | 1 | Stop bit was sampled low |
| wake_o | output | 1 | Sticky wakeup request |

## Verification
The data byte, `rx_ne_o`, `addr_match_o` and `frame_err_o` change two clock edges after the cycle that samples the stop-bit centre. A start-bit wakeup follows two edges after the start-bit centre sample, and the other wake sources follow the stop sample with the same two-edge delay. The scoreboard monitor samples on falling clock edges and compares a queued expected character when a flag appears, so it does not depend on the exact edge. Wakeup and held-data checks are made after each frame's trailing idle gap of at least three bit times, which is longer than every one of these delays. False-start and no-wake checks are made after the same gap.

// File: rtl/lprx_pkg.sv
package lprx_pkg;
  localparam int FRAC_BITS = 8;

  typedef enum logic [1:0] {
    WK_START = 2'b00,
    WK_ADDR  = 2'b01,
    WK_RXNE  = 2'b10,
    WK_NONE  = 2'b11
  } wake_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/lprx_sync.sv
module lprx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= 1'b1;
        else     sr <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/lprx_baud.sv
module lprx_baud #(
  parameter int DIV_W = 16,
  parameter int FRAC  = lprx_pkg::FRAC_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int RW = DIV_W + 1;
  localparam logic [RW-1:0]    UNIT    = RW'(1 << FRAC);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(3 << FRAC);

  // Remaining time to the next sample point, in 1/2^FRAC clocks.
  logic [RW-1:0] rem;
  logic [RW-1:0] div_x;

  assign div_x  = {1'b0, div_i};
  assign tick_o = en_i && (rem < UNIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
    end else if (load_i) begin
      // The detection cycle already counts as one elapsed clock.
      rem <= (div_x >> 1) - UNIT;
    end else if (en_i) begin
      if (tick_o) rem <= rem + div_x - UNIT;
      else        rem <= rem - UNIT;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R2
  AST_DIV_MIN: assert property (@(posedge clk) disable iff (rst)
    en_i |-> (div_i >= DIV_MIN)); // R2
endmodule

// File: rtl/lprx_frame.sv
module lprx_frame
  import lprx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxs_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              load_o,
  output logic              start_ok_o,
  output logic              ok_o,
  output logic              bad_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CW = $clog2(DATA_W);

  rx_state_e         st;
  logic              rx_q;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sh;
  logic              fall;

  assign fall   = rx_q && !rxs_i;
  assign busy_o = (st != ST_IDLE);
  assign load_o = (st == ST_IDLE) && fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      rx_q       <= 1'b1;
      cnt        <= '0;
      sh         <= '0;
      data_o     <= '0;
      start_ok_o <= 1'b0;
      ok_o       <= 1'b0;
      bad_o      <= 1'b0;
    end else begin
      rx_q       <= rxs_i;
      start_ok_o <= 1'b0;
      ok_o       <= 1'b0;
      bad_o      <= 1'b0;
      case (st)
        ST_IDLE: if (fall) st <= ST_START;
        ST_START: if (tick_i) begin
          if (!rxs_i) begin
            st         <= ST_DATA;
            cnt        <= '0;
            start_ok_o <= 1'b1;
          end else begin
            st <= ST_IDLE;  // glitch: line back high at mid-bit
          end
        end
        ST_DATA: if (tick_i) begin
          sh <= {rxs_i, sh[DATA_W-1:1]};
          if (cnt == CW'(DATA_W - 1)) st <= ST_STOP;
          cnt <= cnt + 1'b1;
        end
        ST_STOP: if (tick_i) begin
          if (rxs_i) begin
            ok_o   <= 1'b1;
            data_o <= sh;
          end else begin
            bad_o <= 1'b1;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_OK_BAD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ok_o && bad_o)); // R4
  AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    start_ok_o |=> !start_ok_o); // R7
endmodule

// File: rtl/lprx_events.sv
module lprx_events
  import lprx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ok_i,
  input  logic              ok_i,
  input  logic              bad_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-2:0] node_i,
  input  logic              rd_i,
  input  logic              stop_i,
  input  logic [1:0]        sel_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ne_o,
  output logic              am_o,
  output logic              ferr_o,
  output logic              wake_o
);
  logic is_match;
  logic wake_evt;

  assign is_match = data_i[DATA_W-1] && (data_i[DATA_W-2:0] == node_i);

  always_comb begin
    case (wake_sel_e'(sel_i))
      WK_START: wake_evt = start_ok_i;
      WK_ADDR:  wake_evt = ok_i && is_match;
      WK_RXNE:  wake_evt = ok_i;
      default:  wake_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      ne_o   <= 1'b0;
      am_o   <= 1'b0;
      ferr_o <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      if (ok_i) begin
        data_o <= data_i;
        am_o   <= is_match;
        ne_o   <= 1'b1;
      end else if (rd_i) begin
        ne_o <= 1'b0;
      end

      if (bad_i)     ferr_o <= 1'b1;
      else if (rd_i) ferr_o <= 1'b0;

      if (stop_i && wake_evt) wake_o <= 1'b1;
      else if (clr_i)         wake_o <= 1'b0;
    end
  end

  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wake_o && !clr_i) |=> wake_o); // R10
  AST_NO_WAKE_RUN: assert property (@(posedge clk) disable iff (rst)
    (!stop_i && !wake_o) |=> !wake_o); // R11
  AST_FERR_KEEPS_NE: assert property (@(posedge clk) disable iff (rst)
    (bad_i && !ne_o) |=> !ne_o); // R4
  AST_AM_IS_ADDR: assert property (@(posedge clk) disable iff (rst)
    am_o |-> data_o[DATA_W-1]); // R8
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !ok_i) |=> !ne_o); // R4
endmodule

// File: rtl/lprx_top.sv
module lprx_top #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  input  logic              stop_i,
  input  logic [1:0]        wake_sel_i,
  input  logic [DATA_W-2:0] node_addr_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              rd_i,
  input  logic              wake_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ne_o,
  output logic              addr_match_o,
  output logic              frame_err_o,
  output logic              wake_o
);
  logic              rxs;
  logic              tick;
  logic              busy;
  logic              load;
  logic              start_ok;
  logic              frm_ok;
  logic              frm_bad;
  logic [DATA_W-1:0] frm_data;

  lprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_i),
    .dout(rxs)
  );

  lprx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst   (rst),
    .load_i(load),
    .en_i  (busy),
    .div_i (baud_div_i),
    .tick_o(tick)
  );

  lprx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .rxs_i     (rxs),
    .tick_i    (tick),
    .busy_o    (busy),
    .load_o    (load),
    .start_ok_o(start_ok),
    .ok_o      (frm_ok),
    .bad_o     (frm_bad),
    .data_o    (frm_data)
  );

  lprx_events #(.DATA_W(DATA_W)) u_events (
    .clk       (clk),
    .rst       (rst),
    .start_ok_i(start_ok),
    .ok_i      (frm_ok),
    .bad_i     (frm_bad),
    .data_i    (frm_data),
    .node_i    (node_addr_i),
    .rd_i      (rd_i),
    .stop_i    (stop_i),
    .sel_i     (wake_sel_i),
    .clr_i     (wake_clr_i),
    .data_o    (rx_data_o),
    .ne_o      (rx_ne_o),
    .am_o      (addr_match_o),
    .ferr_o    (frame_err_o),
    .wake_o    (wake_o)
  );
endmodule

// File: tb/sim_lprx_top.sv
module sim_lprx_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx = 1'b1;
  logic        stop = 1'b0;
  logic [1:0]  sel = 2'b10;
  logic [6:0]  node = 7'h2B;
  logic [15:0] div = 16'd873;
  logic        rd = 1'b0;
  logic        wclr = 1'b0;
  logic [7:0]  dout;
  logic        ne, am, ferr, wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0] expq[$];   // {data, err, addr_match}
  string      tagq[$];

  always #4 clk = ~clk;

  lprx_top u0 (
    .clk(clk), .rst(rst), .rx_i(rx), .stop_i(stop), .wake_sel_i(sel),
    .node_addr_i(node), .baud_div_i(div), .rd_i(rd), .wake_clr_i(wclr),
    .rx_data_o(dout), .rx_ne_o(ne), .addr_match_o(am),
    .frame_err_o(ferr), .wake_o(wake)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: queue the expected result, then shift the frame out.
  task automatic send(input logic [7:0] b, input logic stop_bit, input string req);
    logic em;
    em = stop_bit && b[7] && (b[6:0] == node);
    if (stop_bit) expq.push_back({b, 1'b0, em});
    else          expq.push_back({8'h00, 1'b1, 1'b0});
    tagq.push_back(req);
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      if (k == 0)      rx = 1'b0;
      else if (k == 9) rx = stop_bit;
      else             rx = b[k-1];
      repeat (((k + 1) * int'(div)) / 256 - (k * int'(div)) / 256) @(negedge clk);
    end
    rx = 1'b1;
    repeat (3 * int'(div) / 256 + 6) @(negedge clk);
  endtask

  // Monitor: pop and compare whenever a frame result shows up.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (ne || ferr)) begin
        if (expq.size() == 0) begin
          check("R3", "unexpected result", 32'(ne), 32'd0);
        end else begin
          logic [9:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          if (e[1]) begin
            check(t, "frame_err", 32'(ferr), 32'd1);
            check("R4", "rx_ne on bad stop", 32'(ne), 32'd0);
          end else begin
            check(t, "rx_ne", 32'(ne), 32'd1);
            check(t, "rx_data", 32'(dout), 32'(e[9:2]));
            check("R8", "addr_match", 32'(am), 32'(e[0]));
            check("R4", "frame_err on good frame", 32'(ferr), 32'd0);
          end
        end
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
      end
    end
  end

  task automatic clear_wake();
    @(negedge clk);
    wclr = 1'b1;
    @(negedge clk);
    wclr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "rx_data", 32'(dout), 32'd0);
    check("R1", "rx_ne", 32'(ne), 32'd0);
    check("R1", "addr_match", 32'(am), 32'd0);
    check("R1", "frame_err", 32'(ferr), 32'd0);
    check("R1", "wake", 32'(wake), 32'd0);

    // R2/R3 reception at several divisors, system awake
    stop = 1'b0; sel = 2'b10;
    div = 16'd873;  send(8'hA5, 1'b1, "R2");
    send(8'h3C, 1'b1, "R3");
    div = 16'd768;  send(8'h5A, 1'b1, "R2");
    div = 16'd4096; send(8'hC3, 1'b1, "R2");
    check("R11", "no wake while awake", 32'(wake), 32'd0);
    div = 16'd873;

    // R5 short glitch, asleep with start wake selected
    stop = 1'b1; sel = 2'b00;
    @(negedge clk); rx = 1'b0;
    @(negedge clk); rx = 1'b1;
    repeat (40) @(negedge clk);
    check("R5", "wake after glitch", 32'(wake), 32'd0);
    check("R5", "rx_ne after glitch", 32'(ne), 32'd0);
    check("R5", "frame_err after glitch", 32'(ferr), 32'd0);

    // R7 start wake, also for a frame that fails its stop bit
    send(8'h11, 1'b0, "R4");
    check("R7", "wake on start bit", 32'(wake), 32'd1);
    check("R4", "data held after bad frame", 32'(dout), 32'hC3);
    repeat (20) @(negedge clk);
    check("R10", "wake sticky", 32'(wake), 32'd1);
    clear_wake();
    check("R10", "wake cleared", 32'(wake), 32'd0);

    // R8 address match
    sel = 2'b01;
    send(8'hAC, 1'b1, "R8");
    check("R8", "no wake wrong address", 32'(wake), 32'd0);
    send(8'h2B, 1'b1, "R8");
    check("R8", "no wake data char", 32'(wake), 32'd0);
    send(8'hAB, 1'b1, "R8");
    check("R8", "wake on own address", 32'(wake), 32'd1);
    check("R8", "addr_match held", 32'(am), 32'd1);
    clear_wake();

    // R9 receive-not-empty wake
    sel = 2'b10;
    send(8'h77, 1'b0, "R9");
    check("R9", "no wake on bad frame", 32'(wake), 32'd0);
    send(8'h77, 1'b1, "R9");
    check("R9", "wake on good frame", 32'(wake), 32'd1);
    clear_wake();

    // R6 no source selected
    sel = 2'b11;
    send(8'hAB, 1'b1, "R6");
    check("R6", "no wake with source off", 32'(wake), 32'd0);

    // R11 awake with start source selected
    stop = 1'b0; sel = 2'b00;
    send(8'h42, 1'b1, "R11");
    check("R11", "no wake while awake", 32'(wake), 32'd0);

    repeat (20) @(negedge clk);
    check("R3", "all frames seen", 32'(expq.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule